// File: doc/BRIEF.md
# Serial Converter Register Initialization Sequencer

This block configures an attached data converter once it has powered up and its reset has been released. A single pulse on `start` makes it issue a fixed, ordered series of register writes over a three-wire serial control link. The link consists of a serial clock, a serial data line and an active-low chip select. Each write is one chip-select frame that carries an 8-bit register address followed by a 16-bit data word.

Four writes are always issued. When the `ac_coupled` input is high at the moment `start` is accepted, a fifth write is appended. The serial clock comes from the system clock divided by an even ratio, and chip select stays high for a guaranteed number of serial-clock periods between frames. The block shows `busy` while the series is running and raises `done` one cycle after the last frame closes. `done` stays high until the next start.

Top module: `conv_init_seq`

## Requirements
- R1: After reset and until a start is accepted, chip select is high, the serial clock and serial data are low, and `busy` and `done` are low. No frame is issued.
- R2: With `ac_coupled` low, exactly four frames are sent, with 24-bit words {address, data} in this order: 0x03/0x0002, 0x01/0x0010, 0xC7/0x8001, 0xDE/0x01C0.
- R3: With `ac_coupled` high, the same four frames are followed by a fifth frame carrying 0xE2/0x00C0, five frames in total.
- R4: `ac_coupled` is captured in the cycle that `start` is accepted. Changing it while the series runs does not change the number of frames.
- R5: Each frame carries exactly 24 rising serial-clock edges while chip select is low. Bits go out MSB first, address byte first. The serial clock is low whenever chip select changes and whenever chip select is high.
- R6: Serial data changes only while the serial clock is low, so it is stable for the whole high phase.
- R7: The serial clock is high for CLK_DIV/2 system cycles and has a period of CLK_DIV system cycles.
- R8: Between consecutive frames of one series, chip select stays high for at least GAP_PERIODS*CLK_DIV system cycles.
- R9: `busy` is high from the cycle after `start` is accepted until `done` rises. `done` rises exactly one cycle after the final chip-select rise and holds until the next accepted start. `busy` and `done` are never high together.
- R10: A `start` pulse while `busy` is high is ignored. The series in progress completes unchanged and is not repeated.
- R11: A `start` while `done` is high clears `done` in the next cycle and runs the full series again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the write series (accepted when not busy) |
| ac_coupled | input | 1 | Append the fifth write when high at start |
| busy | output | 1 | Series in progress |
| done | output | 1 | Series finished, held until next start |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_csn | output | 1 | Active-low chip select framing each write |

## Verification
The hardest cases to reach from the ports are a `start` pulse that arrives deep inside a series and an `ac_coupled` flip after the flag has been captured. Both have effects that only appear in the frame count once the series ends. The stimulus drives random series in which `ac_coupled` is inverted right after acceptance and extra `start` pulses land at varied cycles during `busy`. It also includes directed runs that restart straight from `done`. A port monitor rebuilds every frame bit by bit and compares the captured word list, the gap lengths and the `done` timing against values computed in the bench.

// File: rtl/conv_init_pkg.sv
package conv_init_pkg;
  localparam int ADDR_W       = 8;
  localparam int DATA_W       = 16;
  localparam int WORD_W       = ADDR_W + DATA_W;
  localparam int BASE_WRITES  = 4;
  localparam int TOTAL_WRITES = 5;
  localparam int IDX_W        = $clog2(TOTAL_WRITES);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ISSUE, SEQ_WAIT, SEQ_DONE} seq_state_e;
  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_state_e;

  // Ordered write list; the last entry is only used for AC-coupled inputs.
  function automatic word_t write_entry(input logic [IDX_W-1:0] idx);
    word_t w;
    case (idx)
      3'd0:    w = {8'h03, 16'h0002};
      3'd1:    w = {8'h01, 16'h0010};
      3'd2:    w = {8'hC7, 16'h8001};
      3'd3:    w = {8'hDE, 16'h01C0};
      3'd4:    w = {8'hE2, 16'h00C0};
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/conv_half_tick.sv
module conv_half_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));
  assign tick = run && wrap;

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/conv_word_shift.sv
module conv_word_shift
  import conv_init_pkg::*;
#(
  parameter int GAP_HALVES = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  load,
  input  word_t load_word,
  input  logic  load_last,
  output logic  run,
  output logic  ser_clk,
  output logic  ser_data,
  output logic  ser_csn
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int GW    = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

  sh_state_e        st_q, st_d;
  word_t            sreg_q, sreg_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [GW-1:0]    gap_q, gap_d;
  logic             sclk_q, sclk_d;
  logic             csn_q, csn_d;
  logic             last_q, last_d;

  always_comb begin
    st_d   = st_q;
    sreg_d = sreg_q;
    bit_d  = bit_q;
    gap_d  = gap_q;
    sclk_d = sclk_q;
    csn_d  = csn_q;
    last_d = last_q;
    case (st_q)
      SH_IDLE: begin
        if (load) begin
          st_d   = SH_SHIFT;
          sreg_d = load_word;
          bit_d  = '0;
          last_d = load_last;
          csn_d  = 1'b0;
          sclk_d = 1'b0;
        end
      end
      SH_SHIFT: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == BIT_W'(WORD_W - 1)) begin
              csn_d = 1'b1;
              gap_d = '0;
              st_d  = last_q ? SH_IDLE : SH_GAP;
            end else begin
              bit_d  = bit_q + 1'b1;
              sreg_d = {sreg_q[WORD_W-2:0], 1'b0};
            end
          end
        end
      end
      SH_GAP: begin
        if (tick) begin
          if (gap_q == GW'(GAP_HALVES - 1)) st_d = SH_IDLE;
          else                              gap_d = gap_q + 1'b1;
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      sreg_q <= '0;
      bit_q  <= '0;
      gap_q  <= '0;
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
      gap_q  <= gap_d;
      sclk_q <= sclk_d;
      csn_q  <= csn_d;
      last_q <= last_d;
    end
  end

  assign run      = (st_q != SH_IDLE);
  assign ser_clk  = sclk_q;
  assign ser_csn  = csn_q;
  assign ser_data = (st_q == SH_SHIFT) && sreg_q[WORD_W-1];
endmodule

// File: rtl/conv_init_ctrl.sv
module conv_init_ctrl
  import conv_init_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  ac_coupled,
  input  logic  shift_busy,
  output logic  load,
  output word_t load_word,
  output logic  load_last,
  output logic  busy,
  output logic  done
);
  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] lim_q, lim_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    lim_d = lim_q;
    case (st_q)
      SEQ_IDLE, SEQ_DONE: begin
        if (start) begin
          st_d  = SEQ_ISSUE;
          idx_d = '0;
          lim_d = ac_coupled ? IDX_W'(TOTAL_WRITES - 1) : IDX_W'(BASE_WRITES - 1);
        end
      end
      SEQ_ISSUE: st_d = SEQ_WAIT;
      SEQ_WAIT: begin
        if (!shift_busy) begin
          if (idx_q == lim_q) begin
            st_d = SEQ_DONE;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = SEQ_ISSUE;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
      lim_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      lim_q <= lim_d;
    end
  end

  assign load      = (st_q == SEQ_ISSUE);
  assign load_word = write_entry(idx_q);
  assign load_last = (idx_q == lim_q);
  assign busy      = (st_q == SEQ_ISSUE) || (st_q == SEQ_WAIT);
  assign done      = (st_q == SEQ_DONE);
endmodule

// File: rtl/conv_init_seq.sv
module conv_init_seq
  import conv_init_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int GAP_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ac_coupled,
  output logic busy,
  output logic done,
  output logic ser_clk,
  output logic ser_data,
  output logic ser_csn
);
  localparam int GAP_HALVES = 2 * GAP_PERIODS;

  logic  tick;
  logic  shift_run;
  logic  load;
  logic  load_last;
  word_t load_word;

  conv_half_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (shift_run),
    .tick  (tick)
  );

  conv_word_shift #(.GAP_HALVES(GAP_HALVES)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .load_word (load_word),
    .load_last (load_last),
    .run       (shift_run),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_csn   (ser_csn)
  );

  conv_init_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ac_coupled (ac_coupled),
    .shift_busy (shift_run),
    .load       (load),
    .load_word  (load_word),
    .load_last  (load_last),
    .busy       (busy),
    .done       (done)
  );
endmodule

// File: rtl/conv_init_seq_chk.sv
module conv_init_seq_chk #(
  parameter int CLK_DIV     = 4,
  parameter int GAP_PERIODS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_csn
);
  localparam int HALF    = CLK_DIV / 2;
  localparam int GAP_CYC = GAP_PERIODS * CLK_DIV;

  logic [15:0] hi_cnt;
  logic [15:0] cs_hi_cnt;
  logic        frame_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      cs_hi_cnt  <= '0;
      frame_seen <= 1'b0;
    end else begin
      hi_cnt    <= ser_clk ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
      cs_hi_cnt <= ser_csn ? ((cs_hi_cnt == 16'hFFFF) ? cs_hi_cnt : cs_hi_cnt + 1'b1) : '0;
      if (!ser_csn)  frame_seen <= 1'b1;
      else if (done) frame_seen <= 1'b0;
    end
  end

  a_r5_clk_low_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ser_csn |-> !ser_clk);

  a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  a_r7_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (hi_cnt == 16'(HALF)));

  a_r8_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ser_csn) && frame_seen) |-> (cs_hi_cnt >= 16'(GAP_CYC)));

  a_r9_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(ser_csn) && !$past(ser_csn, 2)));

  a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> busy);
endmodule

bind conv_init_seq conv_init_seq_chk #(.CLK_DIV(CLK_DIV), .GAP_PERIODS(GAP_PERIODS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .ser_csn  (ser_csn)
);

// File: tb/test_conv_init_seq.sv
module test_conv_init_seq;
  localparam int CLK_DIV     = 4;
  localparam int GAP_PERIODS = 2;
  localparam int HALF        = CLK_DIV / 2;
  localparam int GAP_CYC     = GAP_PERIODS * CLK_DIV;

  logic clk, rst_n, start, ac_coupled;
  logic busy, done, ser_clk, ser_data, ser_csn;

  conv_init_seq #(.CLK_DIV(CLK_DIV), .GAP_PERIODS(GAP_PERIODS)) i_conv_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ac_coupled(ac_coupled),
    .busy(busy), .done(done), .ser_clk(ser_clk), .ser_data(ser_data), .ser_csn(ser_csn)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(input int i);
    case (i)
      0: return {8'h03, 16'h0002};
      1: return {8'h01, 16'h0010};
      2: return {8'hC7, 16'h8001};
      3: return {8'hDE, 16'h01C0};
      default: return {8'hE2, 16'h00C0};
    endcase
  endfunction

  // Port monitor, sampling at the falling clock edge
  int          cyc = 0;
  logic        prev_sclk = 0, prev_csn = 1, prev_done = 0;
  logic [23:0] cur_word = 0;
  int          cur_bits = 0;
  int          nfr = 0;
  logic [23:0] cap [8];
  int          hi_len = 0;
  int          last_rise = 0;
  int          csn_rise_cyc = 0;
  int          done_rise_cyc = -1;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 150000", cyc);
      finish_run();
    end
    if (rst_n) begin
      if (ser_clk && !prev_sclk && !ser_csn) begin
        if (cur_bits > 0) chk(cyc - last_rise == CLK_DIV, "R7 serial clock period", cyc - last_rise, CLK_DIV);
        cur_word = {cur_word[22:0], ser_data};
        cur_bits++;
        last_rise = cyc;
      end
      if (ser_clk) hi_len++;
      else begin
        if (prev_sclk) chk(hi_len == HALF, "R7 serial clock high time", hi_len, HALF);
        hi_len = 0;
      end
      if (!ser_csn && prev_csn) begin
        if (nfr > 0) chk(cyc - csn_rise_cyc >= GAP_CYC, "R8 chip select gap", cyc - csn_rise_cyc, GAP_CYC);
        chk(!ser_clk, "R5 clock low at frame open", ser_clk, 0);
        cur_bits = 0;
        cur_word = '0;
      end
      if (ser_csn && !prev_csn) begin
        chk(cur_bits == 24, "R5 bits per frame", cur_bits, 24);
        chk(!ser_clk, "R5 clock low at frame close", ser_clk, 0);
        if (nfr < 8) cap[nfr] = cur_word;
        nfr++;
        csn_rise_cyc = cyc;
      end
      if (done && !prev_done) done_rise_cyc = cyc;
    end
    prev_sclk = ser_clk;
    prev_csn  = ser_csn;
    prev_done = done;
  end

  task automatic run_seq(input bit ac, input bit flip, input bit extra, input string tag);
    int n;
    @(posedge clk); #1;
    nfr = 0;
    done_rise_cyc = -1;
    ac_coupled = ac;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R9 busy after start"}, busy, 1);
    chk(done == 1'b0, {tag, " R11 done cleared by start"}, done, 0);
    if (flip) ac_coupled = !ac;
    for (int k = 0; k < 6000; k++) begin
      @(posedge clk); #1;
      if (done) break;
      start = extra && ((k % 137) == 60);
    end
    start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n = ac ? 5 : 4;
    chk(nfr == n, {tag, " R3 R4 R10 frame count"}, nfr, n);
    for (int i = 0; i < n && i < nfr; i++)
      chk(cap[i] == exp_word(i), {tag, (i == 4) ? " R3 fifth word" : " R2 word order"}, cap[i], exp_word(i));
    chk(done_rise_cyc - csn_rise_cyc == 1, {tag, " R9 done one cycle after last frame"},
        done_rise_cyc - csn_rise_cyc, 1);
    chk(done == 1'b1 && busy == 1'b0, {tag, " R9 done held, busy low"}, {done, busy}, 2'b10);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'h5eed);
    rst_n = 1'b0;
    start = 1'b0;
    ac_coupled = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk(ser_csn == 1'b1 && ser_clk == 1'b0 && ser_data == 1'b0, "R1 serial pins in reset",
        {ser_csn, ser_clk, ser_data}, 3'b100);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    chk(busy == 1'b0 && done == 1'b0, "R1 status idle after reset", {busy, done}, 0);
    chk(nfr == 0 && ser_csn == 1'b1, "R1 no frame without start", nfr, 0);

    run_seq(1'b0, 1'b0, 1'b0, "dc");
    repeat (30) @(posedge clk);
    #1;
    chk(done == 1'b1 && ser_csn == 1'b1, "R9 done holds while idle", done, 1);
    run_seq(1'b1, 1'b0, 1'b0, "ac restart R11");
    run_seq(1'b1, 1'b1, 1'b1, "ac flip+starts R4 R10");
    run_seq(1'b0, 1'b1, 1'b1, "dc flip+starts R4 R10");

    for (int t = 0; t < 6; t++) begin
      bit rac, rfl, rex;
      rac = 1'($urandom());
      rfl = 1'($urandom());
      rex = 1'($urandom());
      repeat ($urandom_range(0, 15)) @(posedge clk);
      run_seq(rac, rfl, rex, "random");
    end
    finish_run();
  end
endmodule